// File: doc/BRIEF.md
# Interrupt Event State Buffer Array

This block keeps a two-bit event state for each of a small set of interrupt sources. The high bit (P) means a notification has been sent and not yet finished with an end-of-interrupt. The low bit (Q) means another event came in while P was set. When only Q is set, the source is masked. Software works the block through a memory-mapped access channel. A single access cycle names a source and a page, gives the direction (load or store), and gives bits [11:8] of the byte offset. The direction and offset together pick the operation, and any store data is not used. Every load returns the source's state from before the access, so software can see an event that was folded into one that was already pending.

A trigger comes from one of two places: a store to the source's trigger page, or a rising edge on that source's hardware line. If the source is idle, the trigger produces a notification, which is a one-cycle pulse that carries the source number. If a notification is already outstanding, the trigger is only recorded. If the source is masked, the trigger is dropped. Line edges are held per source and are served in cycles when the access channel is idle, lowest source first. Routing, event-queue writes and address mapping are done outside this block.

Top module: `esb_pq_top`

## Requirements
- R1: After reset every source is in the masked state 01 (P clear, Q set), and rd_valid and notif_valid are low.
- R2: A load on the trigger page, or a load on the event page whose offset selector is anything other than 0x0, 0xC or 0xD, returns the state and leaves it unchanged. A store on the event page whose selector is not 0x4 is ignored.
- R3: A load with selector 0xC (offset 0xC00) on the event page returns the old state and sets it to 00 (unmasked, idle). It sends no notification.
- R4: A load with selector 0xD (offset 0xD00) on the event page returns the old state and sets it to 01 (masked).
- R5: A store on the trigger page is a trigger. It moves 00 to 10 and sends a notification. It moves 10 to 11, leaves 11 at 11, and leaves 01 at 01, and none of these three sends a notification.
- R6: An end-of-interrupt is a load with selector 0x0 or a store with selector 0x4 on the event page. It moves 10 to 00, moves 11 to 10 and sends a notification again, and leaves 00 and 01 unchanged. Only the load form returns data.
- R7: A notification is notif_valid high for exactly one cycle, with notif_src set to the source. It appears on the cycle after the operation that caused it, and at most one is sent per cycle.
- R8: A rising edge on src_line[i] is held as a pending trigger for source i. A pending trigger is applied as in R5 only in a cycle with no access, and the lowest pending index goes first.
- R9: rd_valid rises for one cycle exactly one cycle after each load and never after a store or an idle cycle. rd_pq carries P in bit 1 and Q in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_trig_page | input | 1 | 1 = trigger page, 0 = event page |
| acc_src | input | SRC_W | Source addressed |
| acc_ofs_hi | input | 4 | Offset bits [11:8] |
| src_line | input | NSRC | Hardware trigger lines, one per source |
| rd_valid | output | 1 | Load response valid |
| rd_pq | output | 2 | State before the load (P bit 1, Q bit 0) |
| notif_valid | output | 1 | Notification pulse |
| notif_src | output | SRC_W | Source of the notification |

## Verification
The assertions assume three things about the inputs: acc_src always names an existing source, every input changes synchronously with clk, and acc_valid is low while reset is applied. The bench keeps to these. It picks sources only from 0 to NSRC-1, it drives inputs just after a rising edge, and it holds the access channel idle during reset. The random phase mixes accesses and idle cycles. Line edges therefore sometimes wait behind accesses and sometimes land on a source in every one of the four states.

// File: rtl/esb_pq_pkg.sv
package esb_pq_pkg;

  localparam int PAGE_SEL_W = 4;

  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_MASKED = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_QUEUED = 2'b11;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_QUERY,
    OP_LOAD_EOI,
    OP_STORE_EOI,
    OP_UNMASK,
    OP_MASK,
    OP_TRIGGER
  } esb_op_e;

  typedef struct packed {
    pq_t  pq;
    logic notify;
  } pq_step_t;

  // Direction plus offset selector chooses the operation; data plays no part.
  function automatic esb_op_e decode_access(logic is_store, logic trig_page,
                                            logic [PAGE_SEL_W-1:0] sel);
    esb_op_e op;
    if (trig_page) begin
      op = is_store ? OP_TRIGGER : OP_QUERY;
    end else if (is_store) begin
      op = (sel == 4'h4) ? OP_STORE_EOI : OP_NONE;
    end else begin
      unique case (sel)
        4'h0:    op = OP_LOAD_EOI;
        4'hC:    op = OP_UNMASK;
        4'hD:    op = OP_MASK;
        default: op = OP_QUERY;
      endcase
    end
    return op;
  endfunction

  function automatic logic op_returns_data(esb_op_e op);
    return (op == OP_QUERY) || (op == OP_LOAD_EOI) ||
           (op == OP_UNMASK) || (op == OP_MASK);
  endfunction

  function automatic pq_step_t pq_next(esb_op_e op, pq_t cur);
    pq_step_t r;
    r.pq     = cur;
    r.notify = 1'b0;
    unique case (op)
      OP_TRIGGER: begin
        if (cur == PQ_IDLE) begin
          r.pq     = PQ_PEND;
          r.notify = 1'b1;
        end else if (cur == PQ_PEND) begin
          r.pq = PQ_QUEUED;
        end
      end
      OP_LOAD_EOI, OP_STORE_EOI: begin
        if (cur == PQ_PEND) begin
          r.pq = PQ_IDLE;
        end else if (cur == PQ_QUEUED) begin
          r.pq     = PQ_PEND;
          r.notify = 1'b1;
        end
      end
      OP_UNMASK: r.pq = PQ_IDLE;
      OP_MASK:   r.pq = PQ_MASKED;
      default:   r.pq = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/esb_edge_capture.sv
module esb_edge_capture #(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  line,
  input  logic             busy,
  output logic             grant_valid,
  output logic [SRC_W-1:0] grant_src
);

  logic [NSRC-1:0] line_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] grant_mask;

  assign rise = line & ~line_q;

  // Lowest pending index wins when the access channel is free.
  always_comb begin
    grant_valid = 1'b0;
    grant_src   = '0;
    if (!busy) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (pend_q[i]) begin
          grant_valid = 1'b1;
          grant_src   = SRC_W'(i);
        end
      end
    end
  end

  always_comb begin
    grant_mask = '0;
    for (int i = 0; i < NSRC; i++) begin
      grant_mask[i] = grant_valid && (grant_src == SRC_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= line;
      pend_q <= (pend_q & ~grant_mask) | rise;
    end
  end

endmodule

// File: rtl/esb_pq_array.sv
module esb_pq_array
  import esb_pq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  esb_op_e           op,
  input  logic [SRC_W-1:0]  src,
  output logic [2*NSRC-1:0] pq_all,
  output logic              rd_valid,
  output logic [1:0]        rd_pq,
  output logic              notif_valid,
  output logic [SRC_W-1:0]  notif_src
);

  pq_t      pq_q [NSRC];
  pq_t      cur;
  logic     in_range;
  pq_step_t nxt;

  assign in_range = (int'(src) < NSRC);
  assign cur      = in_range ? pq_q[src] : PQ_MASKED;
  assign nxt      = pq_next(op, cur);

  for (genvar g = 0; g < NSRC; g++) begin : g_flat
    assign pq_all[2*g +: 2] = pq_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSRC; i++) pq_q[i] <= PQ_MASKED;
      rd_valid    <= 1'b0;
      rd_pq       <= '0;
      notif_valid <= 1'b0;
      notif_src   <= '0;
    end else begin
      rd_valid    <= op_valid && op_returns_data(op);
      notif_valid <= op_valid && in_range && nxt.notify;
      if (op_valid) rd_pq <= cur;
      if (op_valid && nxt.notify) notif_src <= src;
      if (op_valid && in_range) pq_q[src] <= nxt.pq;
    end
  end

endmodule

// File: rtl/esb_pq_top.sv
module esb_pq_top
  import esb_pq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic                  acc_store,
  input  logic                  acc_trig_page,
  input  logic [SRC_W-1:0]      acc_src,
  input  logic [PAGE_SEL_W-1:0] acc_ofs_hi,
  input  logic [NSRC-1:0]       src_line,
  output logic                  rd_valid,
  output logic [1:0]            rd_pq,
  output logic                  notif_valid,
  output logic [SRC_W-1:0]      notif_src
);

  logic              grant_valid;
  logic [SRC_W-1:0]  grant_src;
  logic              op_valid;
  esb_op_e           op;
  logic [SRC_W-1:0]  op_src;
  logic [2*NSRC-1:0] pq_all;

  esb_edge_capture #(.NSRC(NSRC), .SRC_W(SRC_W)) edge_i (
    .clk        (clk),
    .rst        (rst),
    .line       (src_line),
    .busy       (acc_valid),
    .grant_valid(grant_valid),
    .grant_src  (grant_src)
  );

  // Accesses take the state port first; held line edges fill idle cycles.
  always_comb begin
    if (acc_valid) begin
      op_valid = 1'b1;
      op       = decode_access(acc_store, acc_trig_page, acc_ofs_hi);
      op_src   = acc_src;
    end else begin
      op_valid = grant_valid;
      op       = grant_valid ? OP_TRIGGER : OP_NONE;
      op_src   = grant_src;
    end
  end

  esb_pq_array #(.NSRC(NSRC), .SRC_W(SRC_W)) state_i (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op         (op),
    .src        (op_src),
    .pq_all     (pq_all),
    .rd_valid   (rd_valid),
    .rd_pq      (rd_pq),
    .notif_valid(notif_valid),
    .notif_src  (notif_src)
  );

endmodule

// File: rtl/esb_pq_chk.sv
module esb_pq_chk #(
  parameter int NSRC  = 8,
  parameter int SRC_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_store,
  input logic              acc_trig_page,
  input logic [SRC_W-1:0]  acc_src,
  input logic [3:0]        acc_ofs_hi,
  input logic [2*NSRC-1:0] pq_all,
  input logic              rd_valid,
  input logic              notif_valid,
  input logic [SRC_W-1:0]  notif_src
);

  function automatic logic [1:0] pq_of(logic [2*NSRC-1:0] v, int s);
    return v[2*s +: 2];
  endfunction

  logic is_load;
  assign is_load = acc_valid && !acc_store;

  assert_unmask_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (is_load && !acc_trig_page && acc_ofs_hi == 4'hC)
      |=> (pq_of(pq_all, int'($past(acc_src))) == 2'b00));

  assert_mask_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (is_load && !acc_trig_page && acc_ofs_hi == 4'hD)
      |=> (pq_of(pq_all, int'($past(acc_src))) == 2'b01));

  assert_masked_trig_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_store && acc_trig_page && pq_of(pq_all, int'(acc_src)) == 2'b01)
      |=> !notif_valid);

  assert_notif_marks_pending_R7: assert property (@(posedge clk) disable iff (rst)
    notif_valid |-> (pq_of(pq_all, int'(notif_src)) == 2'b10));

  assert_access_over_line_R8: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (!notif_valid || notif_src == $past(acc_src)));

  assert_rd_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    is_load |=> rd_valid);

  assert_no_rd_otherwise_R9: assert property (@(posedge clk) disable iff (rst)
    !is_load |=> !rd_valid);

endmodule

bind esb_pq_top esb_pq_chk #(.NSRC(NSRC), .SRC_W(SRC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_store    (acc_store),
  .acc_trig_page(acc_trig_page),
  .acc_src      (acc_src),
  .acc_ofs_hi   (acc_ofs_hi),
  .pq_all       (pq_all),
  .rd_valid     (rd_valid),
  .notif_valid  (notif_valid),
  .notif_src    (notif_src)
);

// File: tb/esb_pq_top_tb_top.sv
`timescale 1ns/1ps
module esb_pq_top_tb_top;

  localparam int NSRC  = 8;
  localparam int SRC_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             acc_valid = 1'b0;
  logic             acc_store = 1'b0;
  logic             acc_trig_page = 1'b0;
  logic [SRC_W-1:0] acc_src = '0;
  logic [3:0]       acc_ofs_hi = '0;
  logic [NSRC-1:0]  src_line = '0;
  logic             rd_valid;
  logic [1:0]       rd_pq;
  logic             notif_valid;
  logic [SRC_W-1:0] notif_src;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  int  m_pq [NSRC];
  bit  m_pend [NSRC];
  bit  m_lprev [NSRC];
  string force_tag = "";

  always #4 clk = ~clk;

  esb_pq_top #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_trig_page(acc_trig_page), .acc_src(acc_src), .acc_ofs_hi(acc_ofs_hi),
    .src_line(src_line), .rd_valid(rd_valid), .rd_pq(rd_pq),
    .notif_valid(notif_valid), .notif_src(notif_src)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int trig_next(int v);
    return (v == 0) ? 2 : (v == 2) ? 3 : v;
  endfunction

  function automatic int eoi_next(int v);
    return (v == 2) ? 0 : (v == 3) ? 2 : v;
  endfunction

  // Reference model: evaluates the inputs just sampled, then compares outputs.
  task automatic model_and_check();
    bit    exp_rv = 0;
    int    exp_rpq = 0;
    bit    exp_nv = 0;
    int    exp_ns = 0;
    string tag = "R2";
    int    g = -1;
    if (!acc_valid)
      for (int i = NSRC - 1; i >= 0; i--) if (m_pend[i]) g = i;
    if (acc_valid) begin
      int s = int'(acc_src);
      int old = m_pq[s];
      int sel = int'(acc_ofs_hi);
      if (acc_trig_page && acc_store) begin
        tag = "R5"; exp_nv = (old == 0); exp_ns = s; m_pq[s] = trig_next(old);
      end else if (acc_trig_page) begin
        exp_rv = 1; exp_rpq = old;
      end else if (!acc_store) begin
        exp_rv = 1; exp_rpq = old;
        if (sel == 0) begin
          tag = "R6"; exp_nv = (old == 3); exp_ns = s; m_pq[s] = eoi_next(old);
        end else if (sel == 12) begin
          tag = "R3"; m_pq[s] = 0;
        end else if (sel == 13) begin
          tag = "R4"; m_pq[s] = 1;
        end
      end else if (sel == 4) begin
        tag = "R6"; exp_nv = (old == 3); exp_ns = s; m_pq[s] = eoi_next(old);
      end
    end else if (g >= 0) begin
      tag = "R8"; exp_nv = (m_pq[g] == 0); exp_ns = g; m_pq[g] = trig_next(m_pq[g]);
      m_pend[g] = 0;
    end
    for (int i = 0; i < NSRC; i++) begin
      if (src_line[i] && !m_lprev[i]) m_pend[i] = 1;
      m_lprev[i] = src_line[i];
    end
    if (force_tag != "") tag = force_tag;
    check("R9", int'(rd_valid), int'(exp_rv));
    if (exp_rv) check(tag, int'(rd_pq), exp_rpq);
    check(tag, int'(notif_valid), int'(exp_nv));
    if (exp_nv) check("R7", int'(notif_src), exp_ns);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_and_check();
  endtask

  task automatic access(bit st, bit tp, int s, int ofs);
    acc_valid = 1; acc_store = st; acc_trig_page = tp;
    acc_src = SRC_W'(s); acc_ofs_hi = 4'(ofs >> 8);
    step();
  endtask

  task automatic idle();
    acc_valid = 0;
    step();
  endtask

  initial begin
    for (int i = 0; i < NSRC; i++) begin
      m_pq[i] = 1; m_pend[i] = 0; m_lprev[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    rst = 0;
    step();
    check("R1", int'(rd_valid), 0);
    check("R1", int'(notif_valid), 0);
    force_tag = "R1";
    for (int s = 0; s < NSRC; s++) access(0, 0, s, 'h800);
    force_tag = "";

    access(1, 1, 0, 'h000);   // masked trigger: dropped (R5)
    access(0, 0, 0, 'hC00);   // unmask returns 01 (R3)
    access(1, 1, 0, 'h000);   // 00 -> 10 notify
    access(1, 1, 0, 'h000);   // 10 -> 11
    access(1, 1, 0, 'h000);   // 11 stays
    access(0, 0, 0, 'hC00);   // returns 11: Q seen by software (R3)
    access(0, 0, 0, 'h800);

    access(0, 0, 1, 'hC00);
    access(1, 1, 1, 'h000);
    access(1, 0, 1, 'h400);   // store EOI 10 -> 00 (R6)
    access(1, 1, 1, 'h000);
    access(1, 1, 1, 'h000);
    access(0, 0, 1, 'h000);   // load EOI on 11: renotify (R6)
    access(0, 0, 1, 'h0F0);   // low offset bits do not matter
    access(0, 0, 1, 'hD00);   // mask (R4)
    access(1, 0, 1, 'h400);   // EOI on masked source stays 01
    access(1, 0, 1, 'h800);   // ignored store (R2)
    access(0, 1, 1, 'h000);   // trigger-page load is a query (R2)
    idle();

    for (int s = 2; s < 6; s++) access(0, 0, s, 'hC00);
    src_line[5] = 1; src_line[3] = 1;
    access(0, 0, 0, 'h800);   // edges wait behind accesses (R8)
    access(0, 0, 0, 'h800);
    repeat (4) idle();
    src_line = '0;
    idle();
    src_line[3] = 1;          // second edge: 10 -> 11 silently
    repeat (3) idle();

    for (int n = 0; n < 600; n++) begin
      int pick = int'($urandom_range(0, 5));
      int ofs_tab [6] = '{'h000, 'h400, 'hC00, 'hD00, 'h800, 'h100};
      if ($urandom_range(0, 3) == 0) src_line[$urandom_range(0, NSRC-1)] ^= 1'b1;
      if ($urandom_range(0, 3) == 0) idle();
      else access(1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0),
                  int'($urandom_range(0, NSRC-1)), ofs_tab[pick]);
    end
    acc_valid = 0;
    repeat (NSRC + 2) idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule